// File: doc/BRIEF.md
# EOI-Driven Interrupt Redirection Throttle

This block sits inside an I/O interrupt controller and reacts to end-of-interrupt (EOI) broadcasts. It keeps a table of redirection entries, one per input pin. Each entry holds a vector, a trigger mode (level or edge), a mask bit and a remote-IRR flag. It also samples one pending bit per pin from the pin level inputs. When an EOI for a vector arrives, the block walks the whole table, one entry per clock. For each level-triggered entry with that vector whose remote-IRR flag is set, it clears the flag. If the pin is still pending and the entry is unmasked, it asks for the interrupt to be delivered again.

A guest that never quiets its level-triggered source would otherwise see the interrupt delivered again after every EOI without end. To stop that, the block counts successive re-deliveries per vector. When the count reaches a storm limit, the counter restarts and the re-delivery is held back by a fixed delay. During that delay the guest can make progress. Pins deferred while the delay timer runs are all released when it expires, one per cycle.

Software writes the table through a simple write port. Service requests leave the block as a one-cycle strobe that carries a pin index. Issuing a request for a level-triggered entry sets that entry's remote-IRR flag again.

Top module: `eoi_throttle`

## Requirements
- R1: An EOI affects only entries whose vector equals the EOI vector.
- R2: Entries with edge trigger mode (trigger bit 0) are skipped even when their vector matches.
- R3: A matching level entry (trigger bit 1) whose remote-IRR flag is clear is skipped: no service and no change to the counter.
- R4: For a matching level entry with remote-IRR set, the flag is cleared. If the entry is unmasked (mask bit 0) and its pin is pending, and the incremented per-vector counter stays below STORM_LIMIT, `svcReq` pulses with `svcPin` equal to the entry index. The pulse appears 2+index cycles after the EOI is sampled. Issuing the request sets remote-IRR again for a level entry.
- R5: A matching level entry with remote-IRR set that is masked, or whose pin is not pending, resets that vector's counter to zero and requests nothing.
- R6: When the incremented counter reaches STORM_LIMIT, the counter returns to zero and no immediate request is made. The block arms a one-shot timer, and the request for that pin appears DELAY_CYCLES+1 cycles after the cycle in which it would have been issued immediately.
- R7: Arming the timer while it is already running keeps the original expiry. All pins deferred in that window are issued after expiry, lowest index first, one per cycle. A request from the table walk takes precedence over a deferred one in the same cycle.
- R8: `busy` is high for exactly NUM_PINS cycles after an accepted EOI. An EOI presented while `busy` is high is ignored.
- R9: While reset is applied and right after it, `busy` and `svcReq` are low.
- R10: A write with `cfgWrEn` loads the vector, trigger, mask and remote-IRR of entry `cfgPin` in one cycle. A write to an index at or above NUM_PINS is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Entry write strobe |
| cfgPin | input | $clog2(NUM_PINS) | Entry index to write |
| cfgVector | input | VEC_W | Vector to store |
| cfgLevel | input | 1 | Trigger mode: 1 level, 0 edge |
| cfgMask | input | 1 | Mask bit: 1 masked |
| cfgRemote | input | 1 | Remote-IRR value to store |
| pinLevel | input | NUM_PINS | Per-pin request levels, sampled into the pending bits |
| eoiValid | input | 1 | EOI broadcast strobe |
| eoiVector | input | VEC_W | Vector of the EOI broadcast |
| busy | output | 1 | Table walk in progress |
| svcReq | output | 1 | One-cycle service request |
| svcPin | output | $clog2(NUM_PINS) | Pin index of the service request |

## Verification
The bench builds the block with 24 pins, 8-bit vectors, STORM_LIMIT of 4 and DELAY_CYCLES of 200. A limit of 4 lets a storm build from a handful of EOIs. A 200-cycle delay is long enough that a second vector can reach its own storm limit while the timer is still running, which exercises the keep-earlier-expiry rule and the lowest-first release. A masked entry on the storm vector clears its flag once and resets the counter, which moves the storm onto the fifth EOI instead of the fourth. Each expected request is keyed to its exact arrival cycle.

// File: rtl/eoithr_pkg.sv
package eoithr_pkg;

  // Per-entry control flags of a redirection entry.
  typedef struct packed {
    logic level;   // 1: level-triggered, 0: edge-triggered
    logic masked;  // 1: entry masked
    logic remote;  // remote-IRR flag
  } entryFlags_t;

  // Strobes from the scan control to the datapath.
  typedef struct packed {
    logic scanStep;  // evaluate the entry at scanIdx this cycle
  } scanCtl_t;

endpackage

// File: rtl/eoithr_control.sv
module eoithr_control
  import eoithr_pkg::*;
#(
  parameter int NUM_PINS = 24,
  parameter int VEC_W    = 8,
  localparam int PIN_W   = $clog2(NUM_PINS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             eoiValid,
  input  logic [VEC_W-1:0] eoiVector,
  output scanCtl_t         ctl,
  output logic [PIN_W-1:0] scanIdx,
  output logic [VEC_W-1:0] scanVector,
  output logic             busy
);
  localparam logic [PIN_W-1:0] LAST_IDX = PIN_W'(NUM_PINS - 1);

  typedef enum logic {ST_IDLE, ST_SCAN} scanState_e;
  scanState_e state;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      scanIdx    <= '0;
      scanVector <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (eoiValid) begin
          state      <= ST_SCAN;
          scanIdx    <= '0;
          scanVector <= eoiVector;
        end
        ST_SCAN: begin
          if (scanIdx == LAST_IDX) state <= ST_IDLE;
          else                     scanIdx <= scanIdx + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy         = (state == ST_SCAN);
  assign ctl.scanStep = (state == ST_SCAN);

endmodule

// File: rtl/eoithr_delay.sv
module eoithr_delay #(
  parameter int NUM_PINS     = 24,
  parameter int DELAY_CYCLES = 2500000,
  localparam int PIN_W       = $clog2(NUM_PINS),
  localparam int TMR_W       = $clog2(DELAY_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             armReq,
  input  logic [PIN_W-1:0] armPin,
  input  logic             drainAccept,
  output logic             drainValid,
  output logic [PIN_W-1:0] drainPin,
  output logic             timerRun,
  output logic             timerFire
);
  logic [TMR_W-1:0]    timerCnt;
  logic [NUM_PINS-1:0] waitMask;
  logic [NUM_PINS-1:0] drainMask;
  logic [NUM_PINS-1:0] waitNext;
  logic [NUM_PINS-1:0] drainNext;

  assign timerFire  = timerRun && (timerCnt == '0);
  assign drainValid = |drainMask;

  // Lowest set bit wins.
  always_comb begin
    drainPin = '0;
    for (int i = NUM_PINS - 1; i >= 0; i--) begin
      if (drainMask[i]) drainPin = PIN_W'(i);
    end
  end

  always_comb begin
    waitNext  = timerFire ? '0 : waitMask;
    if (armReq) waitNext[armPin] = 1'b1;
    drainNext = drainMask | (timerFire ? waitMask : '0);
    if (drainAccept) drainNext[drainPin] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      timerRun  <= 1'b0;
      timerCnt  <= '0;
      waitMask  <= '0;
      drainMask <= '0;
    end else begin
      waitMask  <= waitNext;
      drainMask <= drainNext;
      if (armReq && (!timerRun || timerFire)) begin
        timerRun <= 1'b1;
        timerCnt <= TMR_W'(DELAY_CYCLES - 1);
      end else if (timerFire) begin
        timerRun <= 1'b0;
      end else if (timerRun) begin
        timerCnt <= timerCnt - 1'b1;
      end
    end
  end

endmodule

// File: rtl/eoithr_datapath.sv
module eoithr_datapath
  import eoithr_pkg::*;
#(
  parameter int NUM_PINS    = 24,
  parameter int VEC_W       = 8,
  parameter int STORM_LIMIT = 10000,
  localparam int PIN_W      = $clog2(NUM_PINS),
  localparam int NUM_VEC    = 1 << VEC_W,
  localparam int CNT_W      = $clog2(STORM_LIMIT + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfgWrEn,
  input  logic [PIN_W-1:0]    cfgPin,
  input  logic [VEC_W-1:0]    cfgVector,
  input  logic                cfgLevel,
  input  logic                cfgMask,
  input  logic                cfgRemote,
  input  logic [NUM_PINS-1:0] pinLevel,
  input  scanCtl_t            ctl,
  input  logic [PIN_W-1:0]    scanIdx,
  input  logic [VEC_W-1:0]    scanVector,
  input  logic                drainValid,
  input  logic [PIN_W-1:0]    drainPin,
  output logic                armReq,
  output logic [PIN_W-1:0]    armPin,
  output logic                drainAccept,
  output logic                svcReq,
  output logic [PIN_W-1:0]    svcPin
);
  logic [VEC_W-1:0]    vecTab [NUM_PINS];
  entryFlags_t         flags  [NUM_PINS];
  logic [CNT_W-1:0]    vecCnt [NUM_VEC];
  logic [NUM_PINS-1:0] pendQ;

  entryFlags_t      curFlags;
  logic             hit, live, storm, scanSvc, cfgOk;
  logic [CNT_W-1:0] cntNext;

  always_comb begin
    curFlags    = flags[scanIdx];
    hit         = ctl.scanStep && (vecTab[scanIdx] == scanVector)
                  && curFlags.level && curFlags.remote;
    live        = !curFlags.masked && pendQ[scanIdx];
    cntNext     = vecCnt[scanVector] + 1'b1;
    storm       = (cntNext >= CNT_W'(STORM_LIMIT));
    scanSvc     = hit && live && !storm;
    armReq      = hit && live && storm;
    armPin      = scanIdx;
    drainAccept = drainValid && !scanSvc;
    cfgOk       = cfgWrEn && (int'(cfgPin) < NUM_PINS);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int p = 0; p < NUM_PINS; p++) begin
        vecTab[p] <= '0;
        flags[p]  <= '{level: 1'b0, masked: 1'b1, remote: 1'b0};
      end
      for (int v = 0; v < NUM_VEC; v++) vecCnt[v] <= '0;
      pendQ  <= '0;
      svcReq <= 1'b0;
      svcPin <= '0;
    end else begin
      pendQ  <= pinLevel;
      svcReq <= scanSvc || drainAccept;
      svcPin <= scanSvc ? scanIdx : drainPin;
      if (hit) begin
        // Cleared, or set again at once when the request is issued now.
        flags[scanIdx].remote <= scanSvc;
        vecCnt[scanVector]    <= (live && !storm) ? cntNext : '0;
      end
      if (drainAccept && flags[drainPin].level) flags[drainPin].remote <= 1'b1;
      if (cfgOk) begin
        vecTab[cfgPin] <= cfgVector;
        flags[cfgPin]  <= '{level: cfgLevel, masked: cfgMask, remote: cfgRemote};
      end
    end
  end

endmodule

// File: rtl/eoi_throttle.sv
module eoi_throttle
  import eoithr_pkg::*;
#(
  parameter int NUM_PINS     = 24,
  parameter int VEC_W        = 8,
  parameter int STORM_LIMIT  = 10000,
  parameter int DELAY_CYCLES = 2500000,
  localparam int PIN_W       = $clog2(NUM_PINS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfgWrEn,
  input  logic [PIN_W-1:0]    cfgPin,
  input  logic [VEC_W-1:0]    cfgVector,
  input  logic                cfgLevel,
  input  logic                cfgMask,
  input  logic                cfgRemote,
  input  logic [NUM_PINS-1:0] pinLevel,
  input  logic                eoiValid,
  input  logic [VEC_W-1:0]    eoiVector,
  output logic                busy,
  output logic                svcReq,
  output logic [PIN_W-1:0]    svcPin
);
  scanCtl_t         ctl;
  logic [PIN_W-1:0] scanIdx, armPin, drainPin;
  logic [VEC_W-1:0] scanVector;
  logic             armReq, drainAccept, drainValid, timerRun, timerFire;

  eoithr_control #(.NUM_PINS(NUM_PINS), .VEC_W(VEC_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .eoiValid(eoiValid), .eoiVector(eoiVector),
    .ctl(ctl), .scanIdx(scanIdx), .scanVector(scanVector), .busy(busy)
  );

  eoithr_datapath #(.NUM_PINS(NUM_PINS), .VEC_W(VEC_W), .STORM_LIMIT(STORM_LIMIT)) u_dp (
    .clk(clk), .rst_n(rst_n), .cfgWrEn(cfgWrEn), .cfgPin(cfgPin),
    .cfgVector(cfgVector), .cfgLevel(cfgLevel), .cfgMask(cfgMask),
    .cfgRemote(cfgRemote), .pinLevel(pinLevel), .ctl(ctl), .scanIdx(scanIdx),
    .scanVector(scanVector), .drainValid(drainValid), .drainPin(drainPin),
    .armReq(armReq), .armPin(armPin), .drainAccept(drainAccept),
    .svcReq(svcReq), .svcPin(svcPin)
  );

  eoithr_delay #(.NUM_PINS(NUM_PINS), .DELAY_CYCLES(DELAY_CYCLES)) u_delay (
    .clk(clk), .rst_n(rst_n), .armReq(armReq), .armPin(armPin),
    .drainAccept(drainAccept), .drainValid(drainValid), .drainPin(drainPin),
    .timerRun(timerRun), .timerFire(timerFire)
  );

endmodule

// File: rtl/eoithr_checker.sv
module eoithr_checker #(
  parameter int NUM_PINS     = 24,
  parameter int DELAY_CYCLES = 2500000,
  localparam int PIN_W       = $clog2(NUM_PINS),
  localparam int BAGE_W      = $clog2(NUM_PINS + 1) + 1,
  localparam int TAGE_W      = $clog2(DELAY_CYCLES + 1) + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             eoiValid,
  input logic             busy,
  input logic             svcReq,
  input logic [PIN_W-1:0] svcPin,
  input logic             timerRun,
  input logic             timerFire,
  input logic             drainValid
);
  logic [BAGE_W-1:0] busyAge;
  logic [TAGE_W-1:0] timerAge;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busyAge  <= '0;
      timerAge <= '0;
    end else begin
      busyAge  <= busy ? busyAge + 1'b1 : '0;
      timerAge <= (!timerRun || timerFire) ? '0 : timerAge + 1'b1;
    end
  end

  assert_svc_pin_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    svcReq |-> (int'(svcPin) < NUM_PINS));

  assert_busy_from_eoi_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(eoiValid));

  assert_busy_span_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (int'(busyAge) < NUM_PINS));

  assert_timer_no_extend_R7: assert property (@(posedge clk) disable iff (!rst_n)
    timerRun |-> (int'(timerAge) < DELAY_CYCLES));

  assert_svc_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
    svcReq |-> ($past(busy) || $past(drainValid)));

endmodule

bind eoi_throttle eoithr_checker #(.NUM_PINS(NUM_PINS), .DELAY_CYCLES(DELAY_CYCLES)) chk (
  .clk(clk), .rst_n(rst_n), .eoiValid(eoiValid), .busy(busy), .svcReq(svcReq),
  .svcPin(svcPin), .timerRun(timerRun), .timerFire(timerFire), .drainValid(drainValid)
);

// File: tb/eoi_throttle_test.sv
`timescale 1ns/1ps
module eoi_throttle_test;
  localparam int NP = 24, VW = 8, SL = 4, DC = 200, PW = $clog2(NP);

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfgWrEn = 1'b0, cfgLevel = 1'b0, cfgMask = 1'b0, cfgRemote = 1'b0;
  logic [PW-1:0] cfgPin = '0;
  logic [VW-1:0] cfgVector = '0, eoiVector = '0;
  logic [NP-1:0] pinLevel = '0;
  logic eoiValid = 1'b0;
  logic busy, svcReq;
  logic [PW-1:0] svcPin;

  eoi_throttle #(.NUM_PINS(NP), .VEC_W(VW), .STORM_LIMIT(SL), .DELAY_CYCLES(DC)) uut (
    .clk(clk), .rst_n(rst_n), .cfgWrEn(cfgWrEn), .cfgPin(cfgPin), .cfgVector(cfgVector),
    .cfgLevel(cfgLevel), .cfgMask(cfgMask), .cfgRemote(cfgRemote), .pinLevel(pinLevel),
    .eoiValid(eoiValid), .eoiVector(eoiVector), .busy(busy), .svcReq(svcReq), .svcPin(svcPin)
  );

  always #2 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, fails = 0, svcSeen = 0;
  bit finished = 1'b0;
  int expPinQ[$];
  int expAtQ[$];
  string expTagQ[$];

  task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic expectSvc(input int pin, input int at, input string tag);
    expPinQ.push_back(pin);
    expAtQ.push_back(at);
    expTagQ.push_back(tag);
  endtask

  // Monitor: match each request to the item due in this cycle.
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (svcReq) begin
        int found = -1;
        svcSeen++;
        for (int k = 0; k < expAtQ.size(); k++) if (expAtQ[k] == cyc) found = k;
        if (found >= 0) begin
          check(int'(svcPin) == expPinQ[found], expTagQ[found], "service pin", int'(svcPin), expPinQ[found]);
          expPinQ.delete(found); expAtQ.delete(found); expTagQ.delete(found);
        end else begin
          check(1'b0, "R1/R2/R3/R5/R6", "unexpected service at cycle", cyc, -1);
        end
      end
      for (int k = expAtQ.size() - 1; k >= 0; k--) begin
        if (expAtQ[k] < cyc) begin
          check(1'b0, expTagQ[k], "missing service, due cycle", cyc, expAtQ[k]);
          expPinQ.delete(k); expAtQ.delete(k); expTagQ.delete(k);
        end
      end
    end
  end

  always @(negedge clk) begin
    if (cyc > 6000 && !finished) begin
      finished = 1'b1;
      check(1'b0, "R8", "watchdog expired at cycle", cyc, 6000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic writeEntry(input int pin, input int vec, input bit lvl, input bit msk, input bit rem);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgPin = PW'(pin); cfgVector = VW'(vec);
    cfgLevel = lvl; cfgMask = msk; cfgRemote = rem;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic sendEoi(input int vec, output int c);
    @(negedge clk);
    eoiValid = 1'b1; eoiVector = VW'(vec); c = cyc;
    @(negedge clk);
    eoiValid = 1'b0;
  endtask

  task automatic waitIdle();
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    int c, base, tDeferred;
    pinLevel = '0;
    pinLevel[3] = 1'b1; pinLevel[5] = 1'b1; pinLevel[7] = 1'b1;
    pinLevel[10] = 1'b1; pinLevel[12] = 1'b1;
    repeat (3) @(negedge clk);
    check(busy == 1'b0, "R9", "busy in reset", busy, 0);
    check(svcReq == 1'b0, "R9", "svcReq in reset", svcReq, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy == 1'b0 && svcReq == 1'b0, "R9", "outputs after reset", {busy, svcReq}, 0);

    // R10: table setup. Vector 0x31 holds pins 3,5,7,12; 0x42 holds pin 10.
    writeEntry(3,  'h31, 1'b1, 1'b0, 1'b1);
    writeEntry(5,  'h31, 1'b1, 1'b0, 1'b0);
    writeEntry(7,  'h31, 1'b0, 1'b0, 1'b1);
    writeEntry(10, 'h42, 1'b1, 1'b0, 1'b1);
    writeEntry(12, 'h31, 1'b1, 1'b1, 1'b1);
    writeEntry(30, 'h31, 1'b1, 1'b0, 1'b1);  // out of range: dropped

    // R1 R2 R3 R4 R5: only pin 3 re-served; pin 12 clears and resets the count.
    base = svcSeen;
    sendEoi('h31, c);
    expectSvc(3, c + 5, "R4");
    waitIdle();
    check(svcSeen - base == 1, "R1 R2 R3 R5", "requests after first EOI", svcSeen - base, 1);

    // R8: busy span and ignored EOI during the walk.
    base = svcSeen;
    @(negedge clk);
    eoiValid = 1'b1; eoiVector = 8'h42; c = cyc;
    @(negedge clk);
    eoiVector = 8'h31;
    check(busy == 1'b1, "R8", "busy after EOI", busy, 1);
    @(negedge clk);
    eoiValid = 1'b0;
    expectSvc(10, c + 12, "R1");
    while (cyc < c + 24) @(negedge clk);
    check(busy == 1'b1, "R8", "busy on last step", busy, 1);
    @(negedge clk);
    check(busy == 1'b0, "R8", "busy after walk", busy, 0);
    repeat (2) @(negedge clk);
    check(svcSeen - base == 1, "R8", "requests with ignored EOI", svcSeen - base, 1);

    // Counter 0x31 climbs 1,2,3: all immediate.
    for (int n = 0; n < 3; n++) begin
      sendEoi('h31, c);
      expectSvc(3, c + 5, "R4");
      waitIdle();
    end

    // R5 R6: fifth EOI reaches the limit (the fourth would without the R5 reset).
    base = svcSeen;
    sendEoi('h31, c);
    tDeferred = c + 5 + DC + 1;
    expectSvc(3, tDeferred, "R6");
    waitIdle();
    check(svcSeen - base == 0, "R5 R6", "immediate requests at storm", svcSeen - base, 0);

    // R7: vector 0x42 storms while the timer runs; shares the same expiry.
    for (int n = 0; n < 2; n++) begin
      sendEoi('h42, c);
      expectSvc(10, c + 12, "R4");
      waitIdle();
    end
    sendEoi('h42, c);
    expectSvc(10, tDeferred + 1, "R7");
    waitIdle();
    check(cyc < tDeferred, "R7", "second storm inside timer window", cyc, tDeferred);

    while (cyc < tDeferred + 4) @(negedge clk);
    check(expAtQ.size() == 0, "R7", "deferred items outstanding", expAtQ.size(), 0);

    // R6: counters restarted, remote-IRR set again by the deferred requests.
    sendEoi('h42, c);
    expectSvc(10, c + 12, "R6");
    waitIdle();
    sendEoi('h31, c);
    expectSvc(3, c + 5, "R6");
    waitIdle();

    // R5: pin not pending -> flag cleared, nothing issued.
    pinLevel[3] = 1'b0;
    repeat (2) @(negedge clk);
    base = svcSeen;
    sendEoi('h31, c);
    waitIdle();
    check(svcSeen - base == 0, "R5", "requests with pin idle", svcSeen - base, 0);

    // R3: pending again but remote-IRR now clear -> still nothing.
    pinLevel[3] = 1'b1;
    repeat (2) @(negedge clk);
    base = svcSeen;
    sendEoi('h31, c);
    waitIdle();
    check(svcSeen - base == 0, "R3", "requests with flag clear", svcSeen - base, 0);

    // R10: reload remote-IRR by a write; service returns.
    writeEntry(3, 'h31, 1'b1, 1'b0, 1'b1);
    base = svcSeen;
    sendEoi('h31, c);
    expectSvc(3, c + 5, "R10");
    waitIdle();
    check(svcSeen - base == 1, "R10", "requests after reload", svcSeen - base, 1);

    repeat (4) @(negedge clk);
    check(expAtQ.size() == 0, "R4", "expected items left", expAtQ.size(), 0);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule